// File: doc/BRIEF.md
# Three-wire control port receiver

This block receives configuration writes from a host microcontroller over a three-wire serial bus made of a mode line, a bit clock and a data line. All three lines are asynchronous to the system clock. They are synchronized and oversampled, and data is taken on each detected rising edge of the bus clock. The bus carries no read path.

A byte sent while the mode line is low is an address byte. Its upper six bits must match the device identity for the port to accept the bytes that follow. Its lower two bits choose one of two register groups: a data group for playback settings and a status group for converter setup. Bytes sent while the mode line is high are then decoded into parallel register outputs. The two top bits of a data byte choose the register within the data group. The selection stays in force for any number of bytes, until another address byte arrives.

Top module: `ctl3w_rx`

## Requirements
- R1: After reset every register output is zero, except the power control output, which is 2'b11.
- R2: An address byte is sent with the mode line low, bit 0 first. The port is selected only when bits 7:2 equal the DEV_ID parameter (default 6'b000101). Any other identity deselects the port, and bytes that follow are then ignored. Bytes that arrive before any address byte are also ignored.
- R3: Address bits 1:0 give the group: 00 selects the data group and 10 selects the status group. The codes 01 and 11 are unused, and the data bytes that follow them change no output.
- R4: A selection stays in force across any number of consecutive data bytes sent with the mode line high, until a new address byte replaces it.
- R5: A data-group byte with bits 7:6 = 00 loads volume from bits 5:0.
- R6: A data-group byte with bits 7:6 = 01 loads bass from bits 5:2 and treble from bits 1:0.
- R7: A data-group byte with bits 7:6 = 10 loads de-emphasis from bits 4:3, mute from bit 2 and tone mode from bits 1:0. Bit 5 is ignored.
- R8: A data-group byte with bits 7:6 = 11 loads power control from bits 1:0.
- R9: A status-group byte with bit 7 = 0 loads the clock ratio from bits 5:4, the input format from bits 3:1 and the DC filter enable from bit 0. A status byte with bit 7 = 1 changes no output.
- R10: Any change of the mode line discards a partly received byte, and the next bit starts a new byte.
- R11: A byte changes its register only after its eighth bit is received, and no output moves during bits one to seven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_mode | input | 1 | Bus mode line: low for address, high for data |
| ctl_sck | input | 1 | Bus bit clock, idle high |
| ctl_sdi | input | 1 | Bus serial data, bit 0 first |
| clk_ratio | output | 2 | System clock ratio code |
| in_fmt | output | 3 | Serial input format code |
| dc_en | output | 1 | DC filter enable |
| volume | output | 6 | Volume attenuation code |
| bass | output | 4 | Bass boost code |
| treble | output | 2 | Treble code |
| deemph | output | 2 | De-emphasis code |
| mute | output | 1 | Mute enable |
| tone_mode | output | 2 | Tone filter mode |
| pwr_ctl | output | 2 | Converter power control |

## Verification
Every value of each data-group register is swept, along with every status value that has bit 7 clear. After each byte all outputs are compared at once, so a register that catches a neighbour's write or takes the wrong bit slice shows up. Status bytes with bit 7 set are sent, and so are data bytes after a wrong identity, after the unused group codes and before any address. These show that a decode accepted by mistake leaves a visible trace. A byte stopped after seven bits tells a late commit from an early one. A partial byte followed by a mode toggle tells whether the bit counter realigns or carries stale bits into the next byte.

// File: rtl/ctl3w_rx.sv
module ctl3w_rx #(
  parameter logic [5:0] DEV_ID = 6'b000101,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_mode,
  input  logic       ctl_sck,
  input  logic       ctl_sdi,
  output logic [1:0] clk_ratio,
  output logic [2:0] in_fmt,
  output logic       dc_en,
  output logic [5:0] volume,
  output logic [3:0] bass,
  output logic [1:0] treble,
  output logic [1:0] deemph,
  output logic       mute,
  output logic [1:0] tone_mode,
  output logic [1:0] pwr_ctl
);
  localparam int BITS = 8;
  localparam int CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [SYNC_STAGES-1:0] mode_q, sck_q, sdi_q;
  logic mode_s, sck_s, sdi_s, mode_prev, sck_prev;
  logic [BITS-2:0] shreg;
  logic [CW-1:0] cnt;
  logic sel;
  logic [1:0] grp;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= '0;
      sck_q  <= '1;
      sdi_q  <= '0;
    end else begin
      mode_q <= {mode_q[SYNC_STAGES-2:0], ctl_mode};
      sck_q  <= {sck_q[SYNC_STAGES-2:0], ctl_sck};
      sdi_q  <= {sdi_q[SYNC_STAGES-2:0], ctl_sdi};
    end

  assign mode_s = mode_q[SYNC_STAGES-1];
  assign sck_s  = sck_q[SYNC_STAGES-1];
  assign sdi_s  = sdi_q[SYNC_STAGES-1];

  wire sck_rise  = sck_s & ~sck_prev;
  wire mode_flip = mode_s ^ mode_prev;
  wire done      = sck_rise & ~mode_flip & (cnt == LAST);
  wire [BITS-1:0] rx = {sdi_s, shreg};
  wire wr_data   = done & mode_s & sel & (grp == 2'b00);
  wire wr_stat   = done & mode_s & sel & (grp == 2'b10) & ~rx[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_prev <= 1'b0;
      sck_prev  <= 1'b1;
      shreg     <= '0;
      cnt       <= '0;
    end else begin
      mode_prev <= mode_s;
      sck_prev  <= sck_s;
      if (mode_flip) cnt <= '0;
      else if (sck_rise) begin
        shreg <= {sdi_s, shreg[BITS-2:1]};
        cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel <= 1'b0;
      grp <= 2'b00;
    end else if (done && !mode_s) begin
      sel <= (rx[7:2] == DEV_ID);
      grp <= rx[1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      volume    <= '0;
      bass      <= '0;
      treble    <= '0;
      deemph    <= '0;
      mute      <= 1'b0;
      tone_mode <= '0;
      pwr_ctl   <= 2'b11;
    end else if (wr_data) begin
      case (rx[7:6])
        2'b00: volume <= rx[5:0];
        2'b01: begin bass <= rx[5:2]; treble <= rx[1:0]; end
        2'b10: begin deemph <= rx[4:3]; mute <= rx[2]; tone_mode <= rx[1:0]; end
        default: pwr_ctl <= rx[1:0];
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_ratio <= '0;
      in_fmt    <= '0;
      dc_en     <= 1'b0;
    end else if (wr_stat) begin
      clk_ratio <= rx[5:4];
      in_fmt    <= rx[3:1];
      dc_en     <= rx[0];
    end

  wire [24:0] regs = {clk_ratio, in_fmt, dc_en, volume, bass, treble,
                      deemph, mute, tone_mode, pwr_ctl};

  assert_commit_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(regs));
  assert_addr_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_s) |=> $stable(regs));
  assert_unsel_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_s && !sel) |=> $stable(regs));
  assert_unused_grp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_s && grp[0]) |=> $stable(regs));
  assert_stat_hi_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_s && sel && grp == 2'b10 && rx[7]) |=> $stable(regs));
  assert_vol_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && rx[7:6] == 2'b00) |=> (volume == $past(rx[5:0])));
  assert_flip_realign_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flip |=> (cnt == '0));
endmodule

// File: tb/ctl3w_rx_tb.sv
module ctl3w_rx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_mode = 1'b0, ctl_sck = 1'b1, ctl_sdi = 1'b0;
  logic [1:0] clk_ratio, treble, deemph, tone_mode, pwr_ctl;
  logic [2:0] in_fmt;
  logic dc_en, mute;
  logic [5:0] volume;
  logic [3:0] bass;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ctl3w_rx dut_i (.clk(clk), .rst_n(rst_n), .ctl_mode(ctl_mode), .ctl_sck(ctl_sck),
    .ctl_sdi(ctl_sdi), .clk_ratio(clk_ratio), .in_fmt(in_fmt), .dc_en(dc_en),
    .volume(volume), .bass(bass), .treble(treble), .deemph(deemph), .mute(mute),
    .tone_mode(tone_mode), .pwr_ctl(pwr_ctl));

  logic [1:0] e_ratio = 0, e_treb = 0, e_de = 0, e_tone = 0, e_pwr = 2'b11;
  logic [2:0] e_fmt = 0;
  logic e_dc = 0, e_mute = 0, m_sel = 0;
  logic [5:0] e_vol = 0;
  logic [3:0] e_bass = 0;
  logic [1:0] m_grp = 0;

  task automatic model(input logic m, input logic [7:0] b);
    if (!m) begin
      m_sel = (b[7:2] == 6'b000101);
      m_grp = b[1:0];
    end else if (m_sel && m_grp == 2'b00) begin
      case (b[7:6])
        2'b00: e_vol = b[5:0];
        2'b01: begin e_bass = b[5:2]; e_treb = b[1:0]; end
        2'b10: begin e_de = b[4:3]; e_mute = b[2]; e_tone = b[1:0]; end
        default: e_pwr = b[1:0];
      endcase
    end else if (m_sel && m_grp == 2'b10 && !b[7]) begin
      e_ratio = b[5:4]; e_fmt = b[3:1]; e_dc = b[0];
    end
  endtask

  task automatic check(input string req);
    logic [24:0] got, exp;
    got = {clk_ratio, in_fmt, dc_en, volume, bass, treble, deemph, mute, tone_mode, pwr_ctl};
    exp = {e_ratio, e_fmt, e_dc, e_vol, e_bass, e_treb, e_de, e_mute, e_tone, e_pwr};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send_bits(input logic m, input logic [7:0] b, input int n);
    if (ctl_mode != m) begin
      ctl_mode = m;
      repeat (8) @(negedge clk);
    end
    for (int i = 0; i < n; i++) begin
      ctl_sck = 1'b0; ctl_sdi = b[i];
      repeat (8) @(negedge clk);
      ctl_sck = 1'b1;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic send(input logic m, input logic [7:0] b, input string req);
    send_bits(m, b, 8);
    model(m, b);
    check(req);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset values");
    send(1'b1, 8'h15, "R2 data before any address ignored");
    send(1'b0, {6'b000101, 2'b00}, "R2 address select data group");
    for (int v = 0; v < 64; v++) send(1'b1, 8'(v), "R5 volume sweep / R4 persistence");
    for (int v = 0; v < 64; v++) send(1'b1, 8'h40 | 8'(v), "R6 bass treble sweep");
    for (int v = 0; v < 64; v++) send(1'b1, 8'h80 | 8'(v), "R7 deemph mute tone sweep");
    for (int v = 0; v < 4; v++) send(1'b1, 8'hC0 | 8'(v) | 8'h3C, "R8 power control");
    send(1'b0, {6'b000101, 2'b10}, "R3 address select status group");
    for (int v = 0; v < 128; v++) send(1'b1, 8'(v), "R9 status sweep");
    send(1'b1, 8'hBF, "R9 status bit7 set ignored");
    send(1'b1, 8'hC1, "R9 status bit7 set ignored");
    send(1'b0, {6'b000110, 2'b00}, "R2 foreign id deselects");
    send(1'b1, 8'h2A, "R2 byte ignored after deselect");
    send(1'b0, {6'b000101, 2'b01}, "R3 unused code 01");
    send(1'b1, 8'h11, "R3 byte ignored under 01");
    send(1'b0, {6'b000101, 2'b11}, "R3 unused code 11");
    send(1'b1, 8'h80 | 8'h1F, "R3 byte ignored under 11");
    send(1'b0, {6'b000101, 2'b00}, "R4 reselect data group");
    send_bits(1'b1, 8'h3F, 7);
    check("R11 no update after seven bits");
    send_bits(1'b1, 8'h00, 1);
    model(1'b1, 8'h3F);
    check("R11 update on eighth bit");
    send_bits(1'b1, 8'h1B, 5);
    check("R10 partial byte not committed");
    ctl_mode = 1'b0; repeat (8) @(negedge clk);
    ctl_mode = 1'b1; repeat (8) @(negedge clk);
    send(1'b1, 8'h2A, "R10 realigned after mode change");
    send(1'b1, 8'h47, "R4 selection still held");
    finish_run();
  end
endmodule